// File: doc/BRIEF.md
# Multiformat I2S/TDM Transmit Serializer

The block turns parallel audio samples into a serial bit stream on one data line, with a matching frame-sync output. It runs in clock-master fashion. It does not toggle a bit clock itself. Instead, an external divider gives a one-cycle enable pulse (`bclk_en`) for every bit period. On each pulse the block moves its outputs forward by one bit position. Four framings are supported:

- two-slot stereo, with the data delayed by one bit relative to frame sync;
- two-slot stereo, with the data aligned to frame sync;
- multi-slot TDM, with the data delayed by one bit;
- multi-slot TDM, with the data aligned.

The sample length, the slot width, the TDM slot count, the frame-sync pulse width and the order in which channels occupy slots are all configuration inputs.

Each channel has its own valid/ready holding input. A channel is offered exactly one transfer opportunity per frame: the enable-pulse cycle at the first bit of its slot. If the source has no sample valid at that moment, the block sends a fill value instead and raises that channel's underrun flag. The fill is either zero or a repeat of the last value sent, chosen by a mode input. A mono mode copies each left channel into its right partner's slot.

Configuration inputs may change only while `tx_en` is low. Dropping `tx_en` silences the outputs and rewinds the frame to slot 0, bit 0.

Top module: `i2s_tdm_tx`

## Requirements
- R1: With `cfg_fmt`=0, a frame has two slots. `fs_out` is 0 during slot 0 (left, channel 0) and 1 during slot 1 (right, channel 1). Each data bit leaves on `sd_out` one bit period after the position it belongs to, so the MSB follows the frame-sync edge by one bit.
- R2: With `cfg_fmt`=1, a frame has two slots. `fs_out` is 1 during slot 0 and 0 during slot 1. The MSB leaves on the first bit of its slot.
- R3: `cfg_dlen` sets the sample length: 0→32, 1→24, 2→20, 3→18, 4→16, 5→16, 6→8, 7→8 bits. The sample occupies the low bits of the 32-bit input word and is sent MSB first. Slot positions beyond the length carry 0. In the two-slot formats, the slot is 32 bits wide for code 0, 16 bits for codes 4–5 and 8 bits for codes 6–7.
- R4: For `cfg_dlen` codes 1–3 in the two-slot formats, the slot is 24 bits wide when `cfg_slot24`=1 and 32 bits wide when it is 0.
- R5: With `cfg_fmt`=2 or 3, a frame has `cfg_nch_m1`+1 slots of 32 bits each. Code 2 delays data by one bit, like R1. Code 3 aligns data, like R2. `fs_out` rises on the first bit of slot 0.
- R6: In the TDM formats, `cfg_fs_width` sets how long `fs_out` stays high: 0 = one whole slot, 1 = the first (slots×16) bits of the frame, 2 or 3 = one bit.
- R7: In TDM, when `cfg_pair_ilv`=1, slot s carries channel s. When it is 0, the first ceil(N/2) slots carry the even (left) channels 0,2,4,… and the remaining slots carry the odd (right) channels 1,3,5,…, where N is the slot count.
- R8: `smp_ready[c]` is high only in a cycle where `tx_en` and `bclk_en` are both high at the first bit of channel c's slot. A sample transfers when `smp_valid[c]` and `smp_ready[c]` are both high. A source holds valid and data steady until then.
- R9: If `smp_valid[c]` is low at channel c's slot start, the slot carries 0 (when `cfg_fill_repeat`=0) or the value last sent on channel c (when it is 1). `underrun[c]` is high for exactly that one cycle.
- R10: When `cfg_mono`=1, every odd channel's slot carries the value just sent on the even channel below it. The odd channel's ready and underrun stay low.
- R11: While `tx_en` is low, `sd_out`, `fs_out`, `smp_ready` and `underrun` are 0. The next frame starts at slot 0, bit 0, with the one-bit delay stage cleared.
- R12: After reset, `sd_out`, `fs_out`, `smp_ready` and `underrun` are 0, and every channel's last-sent value is 0.
- R13: In a cycle with `tx_en` high and `bclk_en` low, `sd_out` and `fs_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Run enable; low silences the outputs and rewinds the frame |
| bclk_en | input | 1 | One pulse per serial bit period |
| cfg_fmt | input | 2 | Framing: 0 two-slot delayed, 1 two-slot aligned, 2 TDM delayed, 3 TDM aligned |
| cfg_dlen | input | 3 | Sample-length code |
| cfg_slot24 | input | 1 | 24-bit slot for 18/20/24-bit samples |
| cfg_nch_m1 | input | $clog2(NUM_CH) | TDM slot count minus one |
| cfg_fs_width | input | 2 | TDM frame-sync width code |
| cfg_pair_ilv | input | 1 | 1 interleaved pairs, 0 lefts first |
| cfg_mono | input | 1 | Copy left channels into right slots |
| cfg_fill_repeat | input | 1 | Underrun fill: 0 zero, 1 repeat last |
| smp_data | input | NUM_CH*32 | Per-channel sample words, channel c at bits [32c+31:32c] |
| smp_valid | input | NUM_CH | Per-channel sample valid |
| smp_ready | output | NUM_CH | Per-channel sample ready |
| underrun | output | NUM_CH | Per-channel fill-sent pulse |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync |

## Verification
The bench builds the block with the default of eight channels. This lets one build reach every TDM slot count from one to eight, both channel orderings, and mono pairs at every position, including an odd final channel with no partner. The two-slot formats are swept over every length code and both slot-width choices. The TDM formats are swept over every slot count, every frame-sync width code and both orderings. The length code, mono and fill mode vary with each combination. A fixed per-channel pattern withholds every fourth sample, so zero fill and repeat fill both occur, in every slot position.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  localparam int SMP_W = 32;                 // sample word / TDM slot width
  localparam int BIT_W = $clog2(SMP_W) + 1;  // holds 0..SMP_W

  typedef enum logic [1:0] {
    FMT_I2S    = 2'd0,
    FMT_LJ     = 2'd1,
    FMT_TDM    = 2'd2,
    FMT_TDM_LJ = 2'd3
  } fmt_e;

  // Significant bits carried for a length code.
  function automatic logic [BIT_W-1:0] data_bits(input logic [2:0] code);
    case (code)
      3'd0:       return BIT_W'(32);
      3'd1:       return BIT_W'(24);
      3'd2:       return BIT_W'(20);
      3'd3:       return BIT_W'(18);
      3'd4, 3'd5: return BIT_W'(16);
      default:    return BIT_W'(8);
    endcase
  endfunction

  // Bit positions per slot.
  function automatic logic [BIT_W-1:0] slot_bits(input logic tdm, input logic [2:0] code,
                                                 input logic slot24);
    if (tdm) return BIT_W'(SMP_W);
    case (code)
      3'd0:             return BIT_W'(32);
      3'd1, 3'd2, 3'd3: return slot24 ? BIT_W'(24) : BIT_W'(32);
      3'd4, 3'd5:       return BIT_W'(16);
      default:          return BIT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/i2stx_frame_ctr.sv
module i2stx_frame_ctr
  import i2stx_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             bclk_en,
  input  fmt_e             fmt,
  input  logic [2:0]       dlen,
  input  logic             slot24,
  input  logic [CH_W-1:0]  nch_m1,
  input  logic [1:0]       fs_width,
  input  logic             pair_ilv,
  output logic             slot_start,
  output logic [CH_W-1:0]  cur_ch,
  output logic [BIT_W-1:0] bit_idx,
  output logic             fs_val
);
  logic [CH_W-1:0]  slot_q;
  logic [BIT_W-1:0] bit_q;
  logic             tdm;
  logic [CH_W:0]    n_slots;
  logic [CH_W:0]    n_left;
  logic [BIT_W-1:0] slot_len;
  logic             last_bit, last_slot;

  assign tdm       = fmt[1];
  assign n_slots   = tdm ? ({1'b0, nch_m1} + 1'b1) : (CH_W+1)'(2);
  assign n_left    = (n_slots + 1'b1) >> 1;
  assign slot_len  = slot_bits(tdm, dlen, slot24);
  assign last_bit  = (bit_q >= slot_len - 1'b1);
  assign last_slot = ({1'b0, slot_q} >= n_slots - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (bclk_en) begin
      if (last_bit) begin
        bit_q  <= '0;
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign slot_start = tx_en && bclk_en && (bit_q == '0);
  assign bit_idx    = bit_q;

  // Slot to channel: interleaved pairs, or all lefts then all rights.
  logic [CH_W:0] slot_w, ch_w;
  always_comb begin
    slot_w = {1'b0, slot_q};
    if (!tdm || pair_ilv)   ch_w = slot_w;
    else if (slot_w < n_left) ch_w = slot_w << 1;
    else                    ch_w = ((slot_w - n_left) << 1) + 1'b1;
    cur_ch = ch_w[CH_W-1:0];
  end

  // Frame-sync level for the current position.
  logic [15:0] frame_bit, half_bits;
  assign frame_bit = 16'(slot_q) * 16'd32 + 16'(bit_q);
  assign half_bits = 16'(n_slots) * 16'd16;

  always_comb begin
    case (fmt)
      FMT_I2S: fs_val = (slot_q != '0);
      FMT_LJ:  fs_val = (slot_q == '0);
      default: begin
        case (fs_width)
          2'd0:    fs_val = (slot_q == '0);
          2'd1:    fs_val = (frame_bit < half_bits);
          default: fs_val = (slot_q == '0) && (bit_q == '0);
        endcase
      end
    endcase
  end

  AST_CH_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> ({1'b0, cur_ch} < n_slots)); // R7
endmodule

// File: rtl/i2stx_chan_src.sv
module i2stx_chan_src
  import i2stx_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    slot_start,
  input  logic [CH_W-1:0]         cur_ch,
  input  logic                    mono,
  input  logic                    fill_repeat,
  input  logic [NUM_CH*SMP_W-1:0] smp_data,
  input  logic [NUM_CH-1:0]       smp_valid,
  output logic [NUM_CH-1:0]       smp_ready,
  output logic [NUM_CH-1:0]       underrun,
  output logic [SMP_W-1:0]        word_sel
);
  logic [NUM_CH-1:0][SMP_W-1:0] last_all;
  logic [NUM_CH-1:0][SMP_W-1:0] sent_all;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             strobe, dup;
    logic [SMP_W-1:0] partner, sent, last_r;

    assign strobe = slot_start && (cur_ch == CH_W'(c));

    if (c % 2 == 1) begin : g_odd
      assign dup     = mono;
      assign partner = last_all[c-1];
      AST_MONO_RIGHT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mono |-> !smp_ready[c] && !underrun[c]); // R10
    end else begin : g_even
      assign dup     = 1'b0;
      assign partner = '0;
    end

    always_comb begin
      if (dup)               sent = partner;
      else if (smp_valid[c]) sent = smp_data[c*SMP_W +: SMP_W];
      else if (fill_repeat)  sent = last_r;
      else                   sent = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      last_r <= '0;
      else if (strobe) last_r <= sent;
    end

    assign smp_ready[c] = strobe && !dup;
    assign underrun[c]  = strobe && !dup && !smp_valid[c];
    assign last_all[c]  = last_r;
    assign sent_all[c]  = sent;
  end

  assign word_sel = sent_all[cur_ch];

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(smp_ready)); // R8
  AST_URUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun != '0) |=> (underrun == '0)); // R9
endmodule

// File: rtl/i2stx_shift_out.sv
module i2stx_shift_out
  import i2stx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             bclk_en,
  input  fmt_e             fmt,
  input  logic [2:0]       dlen,
  input  logic             slot_start,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             fs_val,
  input  logic [SMP_W-1:0] word_sel,
  output logic             sd_out,
  output logic             fs_out
);
  localparam int PICK_W = $clog2(SMP_W);

  logic [SMP_W-1:0]  word_q, word_cur;
  logic [BIT_W-1:0]  dbits;
  logic [PICK_W-1:0] pick;
  logic              bit_val, lj_q, delayed;

  always_ff @(posedge clk) begin
    if (!rst_n)          word_q <= '0;
    else if (slot_start) word_q <= word_sel;
  end

  assign word_cur = slot_start ? word_sel : word_q;
  assign dbits    = data_bits(dlen);
  assign pick     = PICK_W'(dbits - 1'b1 - bit_idx);
  assign bit_val  = (bit_idx < dbits) ? word_cur[pick] : 1'b0;
  assign delayed  = (fmt == FMT_I2S) || (fmt == FMT_TDM);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      lj_q   <= 1'b0;
      sd_out <= 1'b0;
      fs_out <= 1'b0;
    end else if (bclk_en) begin
      lj_q   <= bit_val;
      sd_out <= delayed ? lj_q : bit_val;
      fs_out <= fs_val;
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && bclk_en && (bit_idx >= dbits) |=> !lj_q); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !sd_out && !fs_out); // R11
  AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !bclk_en |=> $stable(sd_out) && $stable(fs_out)); // R13
endmodule

// File: rtl/i2s_tdm_tx.sv
module i2s_tdm_tx
  import i2stx_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_en,
  input  logic                    bclk_en,
  input  logic [1:0]              cfg_fmt,
  input  logic [2:0]              cfg_dlen,
  input  logic                    cfg_slot24,
  input  logic [CH_W-1:0]         cfg_nch_m1,
  input  logic [1:0]              cfg_fs_width,
  input  logic                    cfg_pair_ilv,
  input  logic                    cfg_mono,
  input  logic                    cfg_fill_repeat,
  input  logic [NUM_CH*SMP_W-1:0] smp_data,
  input  logic [NUM_CH-1:0]       smp_valid,
  output logic [NUM_CH-1:0]       smp_ready,
  output logic [NUM_CH-1:0]       underrun,
  output logic                    sd_out,
  output logic                    fs_out
);
  fmt_e             fmt;
  logic             slot_start, fs_val;
  logic [CH_W-1:0]  cur_ch;
  logic [BIT_W-1:0] bit_idx;
  logic [SMP_W-1:0] word_sel;

  assign fmt = fmt_e'(cfg_fmt);

  i2stx_frame_ctr #(.NUM_CH(NUM_CH)) u_frame (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk_en(bclk_en),
    .fmt(fmt), .dlen(cfg_dlen), .slot24(cfg_slot24), .nch_m1(cfg_nch_m1),
    .fs_width(cfg_fs_width), .pair_ilv(cfg_pair_ilv),
    .slot_start(slot_start), .cur_ch(cur_ch), .bit_idx(bit_idx), .fs_val(fs_val)
  );

  i2stx_chan_src #(.NUM_CH(NUM_CH)) u_src (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .cur_ch(cur_ch),
    .mono(cfg_mono), .fill_repeat(cfg_fill_repeat),
    .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .underrun(underrun), .word_sel(word_sel)
  );

  i2stx_shift_out u_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk_en(bclk_en),
    .fmt(fmt), .dlen(cfg_dlen), .slot_start(slot_start), .bit_idx(bit_idx),
    .fs_val(fs_val), .word_sel(word_sel), .sd_out(sd_out), .fs_out(fs_out)
  );
endmodule

// File: tb/i2s_tdm_tx_tb.sv
`timescale 1ns/1ps
module i2s_tdm_tx_tb;
  localparam int NCH = 8;
  localparam int SW  = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tx_en, bclk_en;
  logic [1:0] cfg_fmt, cfg_fs_width;
  logic [2:0] cfg_dlen, cfg_nch_m1;
  logic cfg_slot24, cfg_pair_ilv, cfg_mono, cfg_fill_repeat;
  logic [NCH*SW-1:0] smp_data;
  logic [NCH-1:0] smp_valid, smp_ready, underrun;
  logic sd_out, fs_out;

  int errs = 0, checks = 0, cyc = 0;
  int m [NCH];
  logic [31:0] last_e [NCH];
  logic prev_lj;

  i2s_tdm_tx #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk_en(bclk_en),
    .cfg_fmt(cfg_fmt), .cfg_dlen(cfg_dlen), .cfg_slot24(cfg_slot24),
    .cfg_nch_m1(cfg_nch_m1), .cfg_fs_width(cfg_fs_width), .cfg_pair_ilv(cfg_pair_ilv),
    .cfg_mono(cfg_mono), .cfg_fill_repeat(cfg_fill_repeat),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .underrun(underrun), .sd_out(sd_out), .fs_out(fs_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++; errs++;
      $display("FAIL R8 watchdog act=%0d exp<%0d", cyc, cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic logic [31:0] gen(int c, int k);
    logic [31:0] x;
    x = 32'h9E3779B9 * 32'(k * 8 + c + 1);
    return x ^ 32'h5A5A_0000;
  endfunction

  task automatic drive_ch(int c);
    smp_valid[c] = (((m[c] + c) % 4) != 3);
    smp_data[c*SW +: SW] = gen(c, m[c]);
  endtask

  function automatic int dbits_of(int code);
    case (code)
      0: return 32; 1: return 24; 2: return 20; 3: return 18;
      4, 5: return 16; default: return 8;
    endcase
  endfunction

  function automatic int slot_of(bit tdm, int code, bit s24);
    if (tdm) return 32;
    case (code)
      0: return 32; 1, 2, 3: return s24 ? 24 : 32;
      4, 5: return 16; default: return 8;
    endcase
  endfunction

  function automatic int map_ch(int s, int n, bit ilv, bit tdm);
    int nl = (n + 1) / 2;
    if (!tdm || ilv) return s;
    return (s < nl) ? 2 * s : 2 * (s - nl) + 1;
  endfunction

  task automatic run_cfg(int fmt, int dlen, bit s24, int nm1, int fsw, bit ilv, bit mono,
                         bit rpt, int frames, bit gap, string tag_sd, string tag_fs);
    bit tdm = (fmt >= 2);
    bit delayed = (fmt == 0) || (fmt == 2);
    int n = tdm ? nm1 + 1 : 2;
    int slen = slot_of(tdm, dlen, s24);
    int db = dbits_of(dlen);
    int nbits = n * slen * frames;
    logic [31:0] cur = '0;
    @(negedge clk);
    tx_en = 1'b0; bclk_en = 1'b1;
    cfg_fmt = 2'(fmt); cfg_dlen = 3'(dlen); cfg_slot24 = s24; cfg_nch_m1 = 3'(nm1);
    cfg_fs_width = 2'(fsw); cfg_pair_ilv = ilv; cfg_mono = mono; cfg_fill_repeat = rpt;
    @(negedge clk);
    chk(sd_out == 1'b0 && fs_out == 1'b0, "R11", "idle outputs", {30'd0, sd_out, fs_out}, 0);
    chk(smp_ready == '0 && underrun == '0, "R11", "idle ready", {smp_ready, underrun}, 0);
    tx_en = 1'b1; bclk_en = 1'b0;
    prev_lj = 1'b0;
    for (int p = 0; p < nbits; p++) begin
      int s = (p / slen) % n;
      int b = p % slen;
      int ch = map_ch(s, n, ilv, tdm);
      bit start = (b == 0);
      bit dup = mono && (ch % 2 == 1);
      logic [NCH-1:0] er, eu;
      bit bv, efs, esd;
      int fb;
      bclk_en = 1'b1;
      #1;
      er = (start && !dup) ? NCH'(1 << ch) : '0;
      eu = er & ~smp_valid;
      chk(smp_ready == er, "R8", "ready", 32'(smp_ready), 32'(er));
      chk(underrun == eu, "R9", "underrun", 32'(underrun), 32'(eu));
      if (start) begin
        if (dup)                cur = last_e[ch-1];
        else if (smp_valid[ch]) cur = gen(ch, m[ch]);
        else                    cur = rpt ? last_e[ch] : 32'd0;
        last_e[ch] = cur;
      end
      bv = (b < db) ? cur[db-1-b] : 1'b0;
      fb = s * 32 + b;
      if (fmt == 0)      efs = (s != 0);
      else if (fmt == 1) efs = (s == 0);
      else if (fsw == 0) efs = (s == 0);
      else if (fsw == 1) efs = (fb < n * 16);
      else               efs = (fb == 0);
      esd = delayed ? prev_lj : bv;
      prev_lj = bv;
      @(posedge clk);
      @(negedge clk);
      chk(sd_out == esd, tag_sd, $sformatf("sd bit p=%0d", p), 32'(sd_out), 32'(esd));
      chk(fs_out == efs, tag_fs, $sformatf("fs p=%0d", p), 32'(fs_out), 32'(efs));
      bclk_en = 1'b0;
      if (start && !dup) begin
        m[ch]++;
        drive_ch(ch);
      end
      if (gap) begin
        @(negedge clk);
        chk(sd_out == esd && fs_out == efs, "R13", "hold without pulse",
            {30'd0, sd_out, fs_out}, {30'd0, esd, efs});
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; bclk_en = 1'b0;
    cfg_fmt = '0; cfg_dlen = '0; cfg_slot24 = 1'b0; cfg_nch_m1 = '0; cfg_fs_width = '0;
    cfg_pair_ilv = 1'b0; cfg_mono = 1'b0; cfg_fill_repeat = 1'b0;
    smp_data = '0; smp_valid = '0;
    for (int c = 0; c < NCH; c++) begin
      m[c] = 0; last_e[c] = '0; drive_ch(c);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(sd_out == 1'b0 && fs_out == 1'b0, "R12", "reset outputs", {30'd0, sd_out, fs_out}, 0);
    chk(smp_ready == '0 && underrun == '0, "R12", "reset ready", {smp_ready, underrun}, 0);

    // Two-slot formats: every length code and slot-width choice (R1 R2 R3 R4 R9 R10)
    for (int f = 0; f < 2; f++)
      for (int d = 0; d < 8; d++)
        for (int w = 0; w < 2; w++)
          run_cfg(f, d, w[0], 7, 0, 1'b0, d[0], w[0] ^ d[1], 3, 1'b1,
                  (f == 0) ? "R1,R3,R4,R9,R10" : "R2,R3,R4,R9,R10",
                  (f == 0) ? "R1" : "R2");

    // TDM formats: every slot count, sync width and ordering (R5 R6 R7 R9 R10)
    for (int f = 2; f < 4; f++)
      for (int fw = 0; fw < 4; fw++)
        for (int il = 0; il < 2; il++)
          for (int k = 0; k < 8; k++)
            run_cfg(f, (k + fw) % 8, fw[0], k, fw, il[0], il[0] ^ f[0] ^ k[2], k[1], 2, 1'b0,
                    "R5,R7,R9,R10", "R5,R6");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule